// File: doc/BRIEF.md
# Integer Compare and Condition Field Writer

This block executes the integer compare instructions of a 32-bit fixed-length RISC encoding. It accepts one instruction word and two 64-bit register operands that the register file has already read. From these it forms a 4-bit condition code in the same cycle. The code holds less-than, greater-than and equal flags, followed by a copy of the summary-overflow bit taken from the fixed-point exception register.

When the execute enable is high, the next clock edge writes the condition code into one of the eight 4-bit fields of a 32-bit condition register. The instruction selects which field. The other seven fields keep their contents.

There are four compare forms: signed against a register, unsigned against a register, signed against a 16-bit immediate, and unsigned against a 16-bit immediate. An instruction bit chooses between a full doubleword compare and a compare of the low 32-bit words. The block recognises only these four forms. Any other instruction word drops the valid output and leaves the condition register untouched.

Top module: `int_compare_unit`

## Requirements
- R1: Primary opcode 31 (bits 31..26) with extended opcode 0 (bits 10..1) compares the A operand with the B operand as signed two's-complement numbers.
- R2: Primary opcode 31 with extended opcode 32 compares the A operand with the B operand as unsigned numbers.
- R3: Primary opcode 11 compares the A operand, taken as signed, with the immediate in bits 15..0 after sign extension.
- R4: Primary opcode 10 compares the A operand, taken as unsigned, with the immediate in bits 15..0 after zero extension.
- R5: Bit 21 selects the width. When it is 1, all 64 operand bits are compared. When it is 0, only the low 32 bits of each side are compared, as signed 32-bit values for the signed forms and as unsigned 32-bit values for the unsigned forms.
- R6: The condition code `cond_o` carries less-than in bit 3, greater-than in bit 2 and equal in bit 1. For a recognised compare, exactly one of these three bits is set.
- R7: Bit 0 of the condition code equals the `so_in` input.
- R8: Bits 25..23 give the field index k. On a write, the code goes into `creg_o[31-4k : 28-4k]`, so field 0 is the most significant nibble. No other bit of the register changes.
- R9: An instruction word that is none of the four compares drives `valid_o` low. It leaves the condition register unchanged even when the execute enable is high.
- R10: The condition register changes only on a clock edge with `exec_en` high and a recognised compare. A synchronous reset clears it to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exec_en | input | 1 | Allows the condition register to be written on this edge |
| instr | input | 32 | Instruction word |
| opnd_a | input | XLEN | A operand, already read from the register file |
| opnd_b | input | XLEN | B operand, already read from the register file |
| so_in | input | 1 | Current summary-overflow bit |
| valid_o | output | 1 | High when the instruction is one of the four compares |
| cond_o | output | 4 | Condition code produced in the same cycle |
| creg_o | output | 32 | Condition register |

## Verification
The bench builds the block with its default XLEN of 64. This makes the high word of each operand visible, so it can disagree with the low word. Chosen operand pairs give opposite results in doubleword and word mode. Others compare equal only after truncation, and one immediate of all ones reads as -1 under sign extension and as 65535 under zero extension.

// File: rtl/int_compare_unit.sv
`timescale 1ns/1ps
module int_compare_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exec_en,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  logic            so_in,
  output logic            valid_o,
  output logic [3:0]      cond_o,
  output logic [31:0]     creg_o
);
  localparam int WORD_W  = 32;
  localparam int IMM_W   = 16;
  localparam int FLD_W   = 4;
  localparam int CR_W    = 32;
  localparam logic [5:0] OP_RR   = 6'd31;
  localparam logic [5:0] OP_SIMM = 6'd11;
  localparam logic [5:0] OP_UIMM = 6'd10;
  localparam logic [9:0] XO_S    = 10'd0;
  localparam logic [9:0] XO_U    = 10'd32;

  wire [5:0] prim = instr[31:26];
  wire [9:0] xo   = instr[10:1];
  wire [2:0] fld  = instr[25:23];
  wire       dbl  = instr[21];

  wire s_rr  = (prim == OP_RR) && (xo == XO_S);
  wire u_rr  = (prim == OP_RR) && (xo == XO_U);
  wire s_imm = (prim == OP_SIMM);
  wire u_imm = (prim == OP_UIMM);

  wire sgn     = s_rr | s_imm;
  wire use_imm = s_imm | u_imm;

  wire unused_fields = &{1'b0, instr[22], instr[20:16], instr[0]};

  wire [XLEN-1:0] imm_ext = {{(XLEN-IMM_W){s_imm & instr[IMM_W-1]}}, instr[IMM_W-1:0]};
  wire [XLEN-1:0] src_b   = use_imm ? imm_ext : opnd_b;

  function automatic logic [XLEN:0] fit(input logic [XLEN-1:0] v,
                                        input logic d, input logic s);
    if (d) return {s & v[XLEN-1], v};
    return {{(XLEN+1-WORD_W){s & v[WORD_W-1]}}, v[WORD_W-1:0]};
  endfunction

  wire [XLEN:0] ea = fit(opnd_a, dbl, sgn);
  wire [XLEN:0] eb = fit(src_b, dbl, sgn);

  wire lt = $signed(ea) < $signed(eb);
  wire gt = $signed(ea) > $signed(eb);
  wire eq = (ea == eb);

  assign valid_o = s_rr | u_rr | s_imm | u_imm;
  assign cond_o  = {lt, gt, eq, so_in};

  always_ff @(posedge clk) begin
    if (rst)
      creg_o <= '0;
    else if (exec_en && valid_o)
      creg_o[CR_W-1-FLD_W*fld -: FLD_W] <= cond_o;
  end
endmodule

module int_compare_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        exec_en,
  input logic [2:0]  fld,
  input logic        rr_eq,
  input logic        valid_o,
  input logic [3:0]  cond_o,
  input logic [31:0] creg_o
);
  function automatic logic [3:0] nib(input logic [31:0] r, input logic [2:0] i);
    return r[31-4*i -: 4];
  endfunction
  function automatic logic [31:0] hole(input logic [31:0] r, input logic [2:0] i);
    logic [31:0] m;
    m = ~(32'hF000_0000 >> (4*i));
    return r & m;
  endfunction

  a_r10_reset_clears: assert property (@(posedge clk) rst |=> creg_o == 32'd0);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !(exec_en && valid_o) |=> $stable(creg_o));
  a_r8_target_field: assert property (@(posedge clk) disable iff (rst)
    (exec_en && valid_o) |=> nib(creg_o, $past(fld)) == $past(cond_o));
  a_r8_other_fields: assert property (@(posedge clk) disable iff (rst)
    (exec_en && valid_o) |=> hole(creg_o, $past(fld)) == hole($past(creg_o), $past(fld)));
  a_r6_one_flag: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $countones(cond_o[3:1]) == 1);
  a_r1_equal_regs: assert property (@(posedge clk) disable iff (rst)
    (valid_o && rr_eq) |-> cond_o[1]);
endmodule

bind int_compare_unit int_compare_unit_chk u_chk (
  .clk(clk), .rst(rst), .exec_en(exec_en), .fld(instr[25:23]),
  .rr_eq(instr[31:26] == 6'd31 && opnd_a == opnd_b),
  .valid_o(valid_o), .cond_o(cond_o), .creg_o(creg_o)
);

// File: tb/int_compare_unit_bench.sv
`timescale 1ns/1ps
module int_compare_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exec_en = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic        so_in = 1'b0;
  logic        valid_o;
  logic [3:0]  cond_o;
  logic [31:0] creg_o;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] model = '0;

  always #2.5 clk = ~clk;

  int_compare_unit u_int_compare_unit (
    .clk(clk), .rst(rst), .exec_en(exec_en), .instr(instr),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .so_in(so_in),
    .valid_o(valid_o), .cond_o(cond_o), .creg_o(creg_o)
  );

  function automatic logic [31:0] mk_rr(input logic [9:0] xo, input logic [2:0] bf, input logic l);
    return {6'd31, bf, 1'b0, l, 5'd3, 5'd4, xo, 1'b0};
  endfunction
  function automatic logic [31:0] mk_imm(input logic [5:0] op, input logic [2:0] bf,
                                         input logic l, input logic [15:0] imm);
    return {op, bf, 1'b0, l, 5'd3, imm};
  endfunction
  function automatic logic [31:0] put(input logic [31:0] r, input logic [2:0] i, input logic [3:0] n);
    logic [31:0] o;
    o = r;
    o[31-4*i -: 4] = n;
    return o;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b,
                       input logic so, input logic en, input logic exp_v,
                       input logic [3:0] exp_n, input string tag);
    @(negedge clk);
    instr = ins; opnd_a = a; opnd_b = b; so_in = so; exec_en = en;
    #1;
    chk(valid_o == exp_v, {tag, " valid"}, {63'd0, valid_o}, {63'd0, exp_v});
    if (exp_v) chk(cond_o == exp_n, {tag, " cond"}, {60'd0, cond_o}, {60'd0, exp_n});
    if (en && exp_v) model = put(model, ins[25:23], exp_n);
    @(negedge clk);
    exec_en = 1'b0;
    chk(creg_o == model, {tag, " creg"}, {32'd0, creg_o}, {32'd0, model});
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk(creg_o == 32'd0, "R10 reset value", {32'd0, creg_o}, 64'd0);
  endtask

  task automatic t_signed_rr;
    apply(mk_rr(10'd0, 3'd2, 1'b1), -64'sd5, 64'd3, 1'b0, 1'b1, 1'b1, 4'b1000, "R1 neg<pos");
    apply(mk_rr(10'd0, 3'd3, 1'b1), 64'd9, -64'sd2, 1'b0, 1'b1, 1'b1, 4'b0100, "R1 pos>neg");
    apply(mk_rr(10'd0, 3'd0, 1'b1), 64'h1234, 64'h1234, 1'b0, 1'b1, 1'b1, 4'b0010, "R1 R6 equal");
  endtask

  task automatic t_unsigned_rr;
    apply(mk_rr(10'd32, 3'd5, 1'b1), -64'sd5, 64'd3, 1'b0, 1'b1, 1'b1, 4'b0100, "R2 big>small");
    apply(mk_rr(10'd32, 3'd6, 1'b1), 64'd1, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 1'b1, 4'b1000, "R2 small<msb");
  endtask

  task automatic t_signed_imm;
    apply(mk_imm(6'd11, 3'd7, 1'b1, 16'hFFFF), -64'sd1, 64'd0, 1'b0, 1'b1, 1'b1, 4'b0010, "R3 -1 eq");
    apply(mk_imm(6'd11, 3'd7, 1'b1, 16'hFFFF), 64'd0, 64'd0, 1'b0, 1'b1, 1'b1, 4'b0100, "R3 0>-1");
  endtask

  task automatic t_unsigned_imm;
    apply(mk_imm(6'd10, 3'd1, 1'b1, 16'hFFFF), 64'd5, 64'd0, 1'b0, 1'b1, 1'b1, 4'b1000, "R4 5<65535");
    apply(mk_imm(6'd10, 3'd1, 1'b1, 16'hFFFF), 64'h0000_0000_0000_FFFF, 64'd0, 1'b0, 1'b1, 1'b1, 4'b0010, "R4 eq");
  endtask

  task automatic t_word_mode;
    apply(mk_rr(10'd0, 3'd4, 1'b0), 64'h0000_0001_8000_0000, 64'd0, 1'b0, 1'b1, 1'b1, 4'b1000, "R5 signed word");
    apply(mk_rr(10'd0, 3'd4, 1'b1), 64'h0000_0001_8000_0000, 64'd0, 1'b0, 1'b1, 1'b1, 4'b0100, "R5 signed dword");
    apply(mk_rr(10'd32, 3'd4, 1'b0), 64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005, 1'b0, 1'b1, 1'b1, 4'b0010, "R5 unsigned word");
    apply(mk_imm(6'd10, 3'd4, 1'b0, 16'h0001), 64'h0000_0000_8000_0000, 64'd0, 1'b0, 1'b1, 1'b1, 4'b0100, "R5 unsigned imm word");
  endtask

  task automatic t_so_copy;
    apply(mk_rr(10'd0, 3'd0, 1'b1), 64'h1234, 64'h1234, 1'b1, 1'b1, 1'b1, 4'b0011, "R7 so set");
    apply(mk_imm(6'd11, 3'd6, 1'b0, 16'h0010), 64'd3, 64'd0, 1'b1, 1'b1, 1'b1, 4'b1001, "R7 so imm");
  endtask

  task automatic t_fields;
    for (int k = 0; k < 8; k++)
      apply(mk_rr(10'd32, k[2:0], 1'b1), 64'd7, 64'd7, k[0], 1'b1, 1'b1, {3'b001, k[0]}, "R8 field walk");
  endtask

  task automatic t_illegal;
    apply(mk_rr(10'd40, 3'd2, 1'b1), 64'd1, 64'd2, 1'b1, 1'b1, 1'b0, 4'b0000, "R9 bad xo");
    apply(mk_imm(6'd12, 3'd3, 1'b1, 16'h0000), 64'd1, 64'd2, 1'b1, 1'b1, 1'b0, 4'b0000, "R9 bad opcode");
  endtask

  task automatic t_enable_reset;
    apply(mk_rr(10'd0, 3'd1, 1'b1), 64'd1, 64'd2, 1'b0, 1'b0, 1'b1, 4'b1000, "R10 enable low");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; model = '0;
    chk(creg_o == 32'd0, "R10 mid reset", {32'd0, creg_o}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    t_signed_rr;
    t_unsigned_rr;
    t_signed_imm;
    t_unsigned_imm;
    t_word_mode;
    t_so_copy;
    t_fields;
    t_illegal;
    t_enable_reset;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #200000;
    nerr++;
    nchk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule